// File: doc/BRIEF.md
# Sixteen-Bit Wrapping Timer with Clear Input

This block is a 16-bit up-counter that sits behind a small byte-wide register port. Software picks what it counts: one count for every four system clocks, or rising edges of an external clock input, which is first brought into the system clock domain. When the count passes from its highest value back to zero, a sticky overflow flag is set. That flag drives an interrupt output through four enable bits, and a separate wake output through three of them.

While the sleep input is high, the count advances only when the timer is counting external edges with its synchronize-disable bit set. A wrap in that state raises the wake output, and the global enable bit has no effect on it.

A compare unit elsewhere can pulse the clear input to restart the count. A clear never sets the overflow flag. It is honoured only when the timer is in synchronous mode on the system-tick source. A software write to either count byte in the same cycle overrides a clear.

Top module: `tick_timer16`

## Requirements
- R1: After reset the count, the control register, the overflow flag, `irq` and `wake` are all zero.
- R2: With control bit 0 (on) set and bit 1 (source) clear, the count rises by one every four system clocks. The first increment lands on the fourth clock edge after the edge that set bit 0.
- R3: An increment from FFFFh gives 0000h and sets the overflow flag, which reads back at bit 0 of address 3.
- R4: The overflow flag stays set until software writes bit 0 of address 3. Writing 0 there clears it.
- R5: `irq` is high exactly when the flag is set and control bits 0 (on), 3 (interrupt enable), 4 (peripheral enable) and 5 (global enable) are all set.
- R6: With bits 0 and 1 set, each rising edge of `ext_clk` adds one to the count after a two-flop synchronizer. With bit 0 clear, edges have no effect.
- R7: While `sleep` is high, the count holds unless bit 1 (source) and bit 2 (synchronize disable) are both set.
- R8: `wake` is high exactly when `sleep` is high, the flag is set, and bits 0, 3 and 4 are set. Bit 5 has no effect on it.
- R9: A `clr_pulse` cycle sets the count to 0000h without setting the flag, even in the cycle it would have wrapped, and whether or not bit 0 is set.
- R10: A write to address 0 (low byte) or address 1 (high byte) in the same cycle as `clr_pulse` stores the written byte and leaves the other byte as it was; the clear is dropped.
- R11: `clr_pulse` has no effect when bit 1 (source) or bit 2 (synchronize disable) is set.
- R12: Writes to address 0 and address 1 load the low and high count bytes. A write takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count low, 1 count high, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ext_clk | input | 1 | External count clock, asynchronous |
| clr_pulse | input | 1 | Count clear request from a compare unit |
| sleep | input | 1 | System sleep indication |
| irq | output | 1 | Overflow interrupt |
| wake | output | 1 | Wake request during sleep |

## Verification
Properties checked on every cycle:
- The count moves by at most one unless written or cleared.
- An increment from the top value wraps and sets the flag.
- A clear that is not overridden leaves zero and does not set the flag.
- The flag holds without a status write.
- The count freezes while sleeping in a non-counting mode.
- `irq` and `wake` never assert without the flag.

Only the bench scenarios show the following:
- The exact divide-by-four timing.
- The count of external edges through the synchronizer.
- The full sweep of the sixteen enable combinations against `irq`.
- The race where a clear lands on the very tick that would have wrapped.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses and the control register layout for
// the wrapping timer. Assumes an 8-bit register port and a 2-bit address.
package tick_timer_pkg;

    localparam int unsigned REG_DATA_W = 8;
    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] A_CNT_LO = 2'd0;
    localparam logic [REG_ADDR_W-1:0] A_CNT_HI = 2'd1;
    localparam logic [REG_ADDR_W-1:0] A_CTRL   = 2'd2;
    localparam logic [REG_ADDR_W-1:0] A_STAT   = 2'd3;

    localparam int unsigned CTRL_W = 6;

    // Control bits, MSB first: global enable down to timer-on.
    typedef struct packed {
        logic glb_en;
        logic per_en;
        logic ovf_ie;
        logic no_sync;
        logic src_ext;
        logic run;
    } tt_ctrl_t;

endpackage

// File: rtl/tt_prescale.sv
`timescale 1ns/1ps
// Prescaler: issues a one-cycle tick every DIV system clocks while run_i is
// high. Restarts its phase whenever run_i is low, so the first tick comes
// DIV-1 cycles after run_i rises. Assumes DIV >= 2.
module tt_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: counts 0..DIV-1 while running, held at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Tick output: high in the last phase of each period.
    always_comb begin
        tick_o = run_i && (phase_q == LAST);
    end
endmodule

// File: rtl/tt_edge_sync.sv
`timescale 1ns/1ps
// External edge detector: a STAGES-deep synchronizer followed by one history
// flop. Emits a one-cycle pulse for each rising edge of async_i, seen in the
// clk domain. Assumes async_i stays high and low for more than STAGES+1
// system clocks.
module tt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    // Synchronizer chain: the first stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= async_i;
        end
    end

    // Remaining stages and the history flop, one per generate step.
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q[g] <= 1'b0;
            end else begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // Rising edge: synchronized level high, history low.
    always_comb begin
        rise_o = chain_q[STAGES-1] && !chain_q[STAGES];
    end
endmodule

// File: rtl/tt_counter.sv
`timescale 1ns/1ps
// Count register with byte loads. Priority is: byte write, then clear, then
// increment. Reports a wrap only when an increment from the top value is
// actually taken. Assumes the caller has already qualified clr_i by mode.
module tt_counter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_i,
    input  logic                  clr_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [2*DATA_W-1:0]   cnt_o,
    output logic                  wrap_o
);
    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             any_wr;

    // Write detect: either byte write blocks clear and increment.
    always_comb begin
        any_wr = wr_lo_i || wr_hi_i;
    end

    // Count update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_lo_i) begin
                cnt_q[DATA_W-1:0] <= wdata_i;
            end
            if (wr_hi_i) begin
                cnt_q[CNT_W-1:DATA_W] <= wdata_i;
            end
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Wrap pulse: an increment is taken at the top value.
    always_comb begin
        wrap_o = inc_i && !clr_i && !any_wr && (cnt_q == TOP);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tt_irq_gate.sv
`timescale 1ns/1ps
// Overflow flag and request gating. A wrap sets the flag and wins over a
// same-cycle status write. The interrupt needs all four enables; the wake
// request needs sleep and three enables, and ignores the global enable.
module tt_irq_gate
    import tick_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wrap_i,
    input  logic     stat_wr_i,
    input  logic     stat_bit_i,
    input  tt_ctrl_t ctrl_i,
    input  logic     sleep_i,
    output logic     flag_o,
    output logic     irq_o,
    output logic     wake_o
);
    logic flag_q;
    logic local_en;

    // Sticky flag: set on wrap, otherwise loaded only by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap_i) begin
            flag_q <= 1'b1;
        end else if (stat_wr_i) begin
            flag_q <= stat_bit_i;
        end
    end

    // Enable chain shared by the interrupt and wake paths.
    always_comb begin
        local_en = flag_q && ctrl_i.run && ctrl_i.ovf_ie && ctrl_i.per_en;
    end

    // Outputs: the interrupt adds the global enable, wake adds sleep.
    always_comb begin
        irq_o  = local_en && ctrl_i.glb_en;
        wake_o = local_en && sleep_i;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tick_timer16.sv
`timescale 1ns/1ps
// Top level of the wrapping timer. Decodes the register port, holds the
// control register, picks the count source and gates it by sleep, and
// qualifies the external clear. Assumes a single clock domain apart from
// ext_clk, which is synchronized inside.
module tick_timer16
    import tick_timer_pkg::*;
#(
    parameter int unsigned DATA_W   = REG_DATA_W,
    parameter int unsigned PRE_DIV  = 4,
    parameter int unsigned SYNC_STG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  ext_clk,
    input  logic                  clr_pulse,
    input  logic                  sleep,
    output logic                  irq,
    output logic                  wake
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    tt_ctrl_t         ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wr_lo, wr_hi, wr_ctrl, wr_stat;
    logic             tick4, ext_rise, src_ok, cnt_inc, clr_ok, wrap;

    // Write decode: one strobe per register.
    always_comb begin
        wr_lo   = wr_en && (wr_addr == A_CNT_LO);
        wr_hi   = wr_en && (wr_addr == A_CNT_HI);
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
        wr_stat = wr_en && (wr_addr == A_STAT);
    end

    // Control register: low CTRL_W bits of the data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= tt_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Divide-by-PRE_DIV tick for the system-tick source.
    tt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctrl_q.run && !ctrl_q.src_ext),
        .tick_o (tick4)
    );

    // External edge detection in the system clock domain.
    tt_edge_sync #(.STAGES(SYNC_STG)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_clk),
        .rise_o  (ext_rise)
    );

    // Count enable: the timer is on, and sleep allows only unsynchronized external mode.
    always_comb begin
        src_ok  = ctrl_q.src_ext ? ext_rise : tick4;
        cnt_inc = ctrl_q.run && src_ok &&
                  (!sleep || (ctrl_q.src_ext && ctrl_q.no_sync));
    end

    // Clear qualification: synchronous tick mode only.
    always_comb begin
        clr_ok = clr_pulse && !ctrl_q.src_ext && !ctrl_q.no_sync;
    end

    // Count register with write-over-clear arbitration.
    tt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (cnt_inc),
        .clr_i   (clr_ok),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (wr_data),
        .cnt_o   (cnt_q),
        .wrap_o  (wrap)
    );

    // Flag, interrupt and wake gating.
    tt_irq_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_i     (wrap),
        .stat_wr_i  (wr_stat),
        .stat_bit_i (wr_data[0]),
        .ctrl_i     (ctrl_q),
        .sleep_i    (sleep),
        .flag_o     (flag_q),
        .irq_o      (irq),
        .wake_o     (wake)
    );

    // Read mux: count bytes, control and status.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CNT_LO: rd_data = cnt_q[DATA_W-1:0];
            A_CNT_HI: rd_data = cnt_q[CNT_W-1:DATA_W];
            A_CTRL:   rd_data = DATA_W'(ctrl_q);
            default:  rd_data = DATA_W'(flag_q);
        endcase
    end
endmodule

// File: rtl/tick_timer16_chk.sv
`timescale 1ns/1ps
// Checker for the wrapping timer: cycle-level properties on the count, the
// flag and the request outputs. Bound into every instance of the top level.
module tick_timer16_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                clr_pulse,
    input logic                sleep,
    input logic [2*DATA_W-1:0] cnt,
    input logic                flag,
    input logic                on,
    input logic                src_ext,
    input logic                no_sync,
    input logic                ie,
    input logic                pe,
    input logic                inc,
    input logic                irq,
    input logic                wake
);
    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] TOP = '1;

    logic wr_cnt, wr_st, clr_ok;

    // Stimulus classification, decoded from the ports.
    always_comb begin
        wr_cnt = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
        wr_st  = wr_en && (wr_addr == 2'd3);
        clr_ok = clr_pulse && !src_ext && !no_sync;
    end

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !clr_ok) |=>
            (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == TOP && !wr_cnt && !clr_ok) |=> (cnt == '0 && flag));

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_st) |=> flag);

    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && on));

    assert_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && !wr_cnt && !clr_ok) |=> $stable(cnt));

    assert_sleep_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !(src_ext && no_sync) && !wr_cnt && !clr_ok) |=> $stable(cnt));

    assert_wake_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && flag && on && ie && pe) |-> wake);

    assert_wake_only_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (sleep && flag));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !wr_cnt) |=> (cnt == '0));

    assert_clear_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !wr_cnt && !flag && !wr_st) |=> !flag);

    assert_write_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && clr_pulse) |=> (cnt[DATA_W-1:0] == $past(wr_data)));
endmodule

bind tick_timer16 tick_timer16_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .clr_pulse (clr_pulse),
    .sleep     (sleep),
    .cnt       (cnt_q),
    .flag      (flag_q),
    .on        (ctrl_q.run),
    .src_ext   (ctrl_q.src_ext),
    .no_sync   (ctrl_q.no_sync),
    .ie        (ctrl_q.ovf_ie),
    .pe        (ctrl_q.per_en),
    .inc       (cnt_inc),
    .irq       (irq),
    .wake      (wake)
);

// File: tb/tb_tick_timer16.sv
`timescale 1ns/1ps
// Bench for the wrapping timer: sweeps over count values, enable patterns and
// clear/write races, with every expected value worked out from the requirements.
module tb_tick_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0;
    logic       clr_pulse = 1'b0;
    logic       sleep = 1'b0;
    logic       irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tick_timer16 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk(ext_clk), .clr_pulse(clr_pulse), .sleep(sleep),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #0.5 wr_en = 1'b0;
    endtask

    task automatic rd8(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a; #0.2 v = rd_data;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] b;
        rd8(2'd0, b); v[7:0] = b;
        rd8(2'd1, b); v[15:8] = b;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic ext_pulse();
        @(negedge clk) ext_clk = 1'b1;
        repeat (3) @(negedge clk);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic race(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; clr_pulse = 1'b1;
        @(posedge clk);
        #0.5 wr_en = 1'b0; clr_pulse = 1'b0;
    endtask

    task automatic clr_only();
        @(negedge clk) clr_pulse = 1'b1;
        @(posedge clk);
        #0.5 clr_pulse = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        logic [7:0]  b;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        rd16(c); chk("R1 count", c, 0);
        rd8(2'd2, b); chk("R1 ctrl", b, 0);
        rd8(2'd3, b); chk("R1 flag", b, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wake", wake, 0);

        // R2: one count per four clocks after turning on
        wr(2'd2, 8'h01);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); rd16(c);
            chk("R2 tick count", c, i / 4);
        end

        // R12: byte loads, and a write beats an increment in the same cycle
        wr(2'd2, 8'h00);
        set_cnt(16'hA5C3);
        @(negedge clk); rd16(c); chk("R12 byte load", c, 16'hA5C3);
        set_cnt(16'h0000);
        wr(2'd2, 8'h01);
        repeat (3) @(posedge clk);
        wr(2'd0, 8'h77);
        @(negedge clk); rd16(c); chk("R12 write over increment", c, 16'h0077);

        // R3 / R5: wrap from FFFC with all enables set
        wr(2'd2, 8'h00);
        set_cnt(16'hFFFC);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h39);
        for (int i = 0; i <= 16; i++) begin
            @(negedge clk); rd16(c);
            chk("R3 wrap count", c, 16'(16'hFFFC + i / 4));
            rd8(2'd3, b);
            chk("R3 flag", b, (i >= 16) ? 1 : 0);
            chk("R5 irq at wrap", irq, (i >= 16) ? 1 : 0);
        end

        // R5 / R4: sweep of the four enables, flag must stay set
        for (int m = 0; m < 16; m++) begin
            wr(2'd2, {2'b00, m[3], m[2], m[1], 2'b00, m[0]});
            @(negedge clk);
            chk("R5 enable sweep irq", irq, (m == 15) ? 1 : 0);
            rd8(2'd3, b); chk("R4 flag sticky", b, 1);
        end
        wr(2'd3, 8'h00);
        @(negedge clk);
        rd8(2'd3, b); chk("R4 flag cleared", b, 0);
        chk("R4 irq after clear", irq, 0);

        // R9: clear on the tick that would wrap from FFFF
        wr(2'd2, 8'h00);
        set_cnt(16'hFFFF);
        wr(2'd2, 8'h01);
        repeat (3) @(posedge clk);
        clr_only();
        @(negedge clk); rd16(c); chk("R9 clear beats wrap", c, 0);
        rd8(2'd3, b); chk("R9 no flag on clear", b, 0);

        // R10: write in the same cycle as a clear
        wr(2'd2, 8'h00);
        set_cnt(16'h1234);
        race(2'd0, 8'h56);
        @(negedge clk); rd16(c); chk("R10 low write beats clear", c, 16'h1256);
        race(2'd1, 8'hAB);
        @(negedge clk); rd16(c); chk("R10 high write beats clear", c, 16'hAB56);
        clr_only();
        @(negedge clk); rd16(c); chk("R9 clear while off", c, 0);

        // R11: clear ignored in external or unsynchronized mode
        set_cnt(16'h0055);
        wr(2'd2, 8'h02);
        clr_only();
        @(negedge clk); rd16(c); chk("R11 clear ignored ext", c, 16'h0055);
        wr(2'd2, 8'h04);
        clr_only();
        @(negedge clk); rd16(c); chk("R11 clear ignored nosync", c, 16'h0055);

        // R6: external edges
        wr(2'd2, 8'h00);
        set_cnt(16'h0000);
        wr(2'd2, 8'h03);
        for (int i = 1; i <= 20; i++) begin
            ext_pulse();
            rd16(c); chk("R6 ext count", c, i);
        end
        wr(2'd2, 8'h02);
        repeat (5) ext_pulse();
        rd16(c); chk("R6 ext while off", c, 20);

        // R7: sleep freezes tick mode and synchronized external mode
        wr(2'd2, 8'h00);
        set_cnt(16'h0100);
        sleep = 1'b1;
        wr(2'd2, 8'h01);
        repeat (20) @(negedge clk);
        rd16(c); chk("R7 tick frozen in sleep", c, 16'h0100);
        wr(2'd2, 8'h03);
        repeat (4) ext_pulse();
        rd16(c); chk("R7 sync ext frozen in sleep", c, 16'h0100);
        wr(2'd2, 8'h07);
        repeat (4) ext_pulse();
        rd16(c); chk("R7 unsync ext counts in sleep", c, 16'h0104);

        // R8: wake on wrap in sleep, with the global enable clear
        wr(2'd2, 8'h06);
        set_cnt(16'hFFFE);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h1F);
        @(negedge clk); chk("R8 wake before wrap", wake, 0);
        repeat (2) ext_pulse();
        rd16(c); chk("R8 wrap count", c, 0);
        rd8(2'd3, b); chk("R8 flag", b, 1);
        chk("R8 wake set", wake, 1);
        chk("R5 irq needs global", irq, 0);
        sleep = 1'b0; #0.2 chk("R8 wake needs sleep", wake, 0);
        @(negedge clk) sleep = 1'b1; #0.2 chk("R8 wake again", wake, 1);
        wr(2'd2, 8'h0F);
        @(negedge clk); chk("R8 wake needs peripheral enable", wake, 0);
        sleep = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule